// File: doc/BRIEF.md
# Endpoint Interrupt Request Controller

The controller sits in the application layer of an endpoint. It turns local interrupt events into one of two kinds of request. When the exported configuration status allows message-signalled interrupts, each event becomes a single memory-write request on a transmit port. The address of that write is the exported message address, and its payload is the exported message data with the vector number folded into its low bits. When message-signalled interrupts are not allowed, events fall back to a level request line for legacy wire interrupts. Raising that line produces an assert message and lowering it produces a deassert message.

Each vector has its own pending bit, and vectors are served lowest number first. A write request handshakes with valid and ready. While MSI-X is enabled and its function mask is set, no write is started, but pending events are kept. The legacy line stays high until software clears the pending condition, and every assertion of the line lasts at least a minimum number of cycles.

One finite-state machine drives both paths. Its four states are: IDLE (no request outstanding), SEND (a write request is offered and waits for ready), LEG_HOLD (the legacy line is high and the minimum width is being counted) and LEG_ON (the legacy line stays high until the clear arrives). Its transitions are: IDLE to SEND when a vector is pending and writes are allowed; SEND to IDLE on the handshake; IDLE to LEG_HOLD when a legacy request is pending and the legacy path is allowed; LEG_HOLD to LEG_ON when the count ends with the request still pending; LEG_HOLD to IDLE when the count ends after the request was cleared; LEG_ON to IDLE when the request is cleared. IDLE checks for a write before it checks the legacy path.

Top module: `irq_req_ctrl`

## Requirements
- R1: After reset, wr_valid_o and legacy_req_o are both 0.
- R2: A write request starts only in a cycle where cfg_status_i[81] (master enable) and cfg_status_i[80] (MSI enable) are both 1 and MSI-X is not masked. Its wr_addr_o is cfg_status_i[63:0] and its base payload is cfg_status_i[79:64].
- R3: msi_ctrl_i[6:4] gives the vector-count exponent n, where 2^n vectors are enabled. The low n bits of wr_data_o are the vector number truncated to n bits. The other payload bits are the base data unchanged, so with n = 0 the payload is the base data.
- R4: An event on evt_i[v] while master and MSI enable are both 1 sets pending bit v. Among pending vectors, the lowest number is served first. A bit clears on the handshake (wr_valid_o and wr_ready_i both 1). A new event on the same vector in that cycle keeps the bit set.
- R5: Once wr_valid_o is 1, it stays 1 with wr_addr_o and wr_data_o stable until the handshake.
- R6: While msix_ctrl_i[15] (MSI-X enable) and msix_ctrl_i[14] (function mask) are both 1, no write starts. Pending bits are kept and are served after the mask is removed.
- R7: An event while MSI is not allowed sets a legacy pending flag. legacy_req_o rises only when cfg_status_i[80] and msix_ctrl_i[15] are both 0, and the flag waits until that holds.
- R8: Once raised, legacy_req_o stays 1 until legacy_clr_i has cleared the pending flag. An event in the same cycle as the clear wins over the clear.
- R9: Each assertion of legacy_req_o lasts at least MIN_HOLD cycles (default 5), even if the clear arrives earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_VEC | Interrupt event pulses, one per vector |
| cfg_status_i | input | 82 | Exported status: master enable, MSI enable, message data, message address |
| msi_ctrl_i | input | 16 | MSI control word; bits 6:4 give the enabled vector exponent |
| msix_ctrl_i | input | 16 | MSI-X control word; bit 15 enable, bit 14 function mask |
| legacy_clr_i | input | 1 | Software clear of the legacy pending condition |
| wr_ready_i | input | 1 | Transmit port accepts the write request |
| wr_valid_o | output | 1 | Write request offered |
| wr_addr_o | output | 64 | Write request address |
| wr_data_o | output | 16 | Write request payload |
| legacy_req_o | output | 1 | Legacy level interrupt request |

## Verification
The checker tests on every cycle the properties that hold at the ports alone. These are: valid and payload held until ready, writes started only when both enables are set and MSI-X is not masked, the legacy line rising only when neither message scheme is enabled, and every legacy pulse being at least the minimum width. Other behaviour needs a history of stimulus, and only the bench scenarios can show it. That covers lowest-first ordering across several pending vectors, pending bits surviving an MSI-X mask, vector truncation for a given enable exponent, the legacy line staying up until the clear, and the guarantee that every random event is served once.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SEND     = 2'd1,
        ST_LEG_HOLD = 2'd2,
        ST_LEG_ON   = 2'd3
    } irq_state_e;

    localparam int STAT_W        = 82;
    localparam int STAT_MASTER   = 81;
    localparam int STAT_MSI_EN   = 80;
    localparam int STAT_DATA_LSB = 64;
    localparam int MSG_DATA_W    = 16;
    localparam int MSG_ADDR_W    = 64;
    localparam int MC_EXP_LSB    = 4;
    localparam int MC_EXP_W      = 3;
    localparam int MX_ENABLE     = 15;
    localparam int MX_FMASK      = 14;
endpackage

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
    parameter int NUM_VEC = 8,
    parameter int VW      = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] set_i,
    input  logic               clr_en_i,
    input  logic [VW-1:0]      clr_idx_i,
    output logic               any_o,
    output logic [VW-1:0]      pick_o
);
    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (clr_en_i && (clr_idx_i == VW'(i))) clr_mask[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | set_i;
    end

    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        pick_o = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (pend_q[i]) pick_o = VW'(i);
        end
    end

    assign any_o = |pend_q;
endmodule

// File: rtl/irq_msg_fmt.sv
module irq_msg_fmt #(
    parameter int VW     = 3,
    parameter int DATA_W = 16,
    parameter int EXP_W  = 3
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [VW-1:0]     vec_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] vec_ext;

    always_comb begin
        low_mask = (DATA_W'(1) << exp_i) - DATA_W'(1);
        vec_ext  = DATA_W'(vec_i);
        data_o   = (base_i & ~low_mask) | (vec_ext & low_mask);
    end
endmodule

// File: rtl/irq_hold_cnt.sv
module irq_hold_cnt #(
    parameter int MIN_HOLD = 5,
    parameter int CW       = $clog2(MIN_HOLD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (start_i)  cnt_q <= '0;
        else if (!done_o)  cnt_q <= cnt_q + CW'(1);
    end

    assign done_o = (cnt_q == CW'(MIN_HOLD - 1));
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_VEC  = 8,
    parameter int MIN_HOLD = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] evt_i,
    input  logic [81:0]        cfg_status_i,
    input  logic [15:0]        msi_ctrl_i,
    input  logic [15:0]        msix_ctrl_i,
    input  logic               legacy_clr_i,
    input  logic               wr_ready_i,
    output logic               wr_valid_o,
    output logic [63:0]        wr_addr_o,
    output logic [15:0]        wr_data_o,
    output logic               legacy_req_o
);
    localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    irq_state_e state_q, state_d;

    logic                  msi_ok, msix_hold, issue_ok, leg_ok, leg_set;
    logic                  handshake, hold_start, hold_done;
    logic                  pend_any, leg_pend_q;
    logic [NUM_VEC-1:0]    msi_set;
    logic [VW-1:0]         pick, vec_q;
    logic [MSG_DATA_W-1:0] fmt_data, data_q;
    logic [MSG_ADDR_W-1:0] addr_q;
    logic                  unused_ok;

    assign unused_ok = ^{msi_ctrl_i[15:7], msi_ctrl_i[3:0], msix_ctrl_i[13:0]};

    assign msi_ok    = cfg_status_i[STAT_MASTER] & cfg_status_i[STAT_MSI_EN];
    assign msix_hold = msix_ctrl_i[MX_ENABLE] & msix_ctrl_i[MX_FMASK];
    assign issue_ok  = msi_ok & ~msix_hold;
    assign leg_ok    = ~cfg_status_i[STAT_MSI_EN] & ~msix_ctrl_i[MX_ENABLE];
    assign msi_set   = msi_ok ? evt_i : '0;
    assign leg_set   = ~msi_ok & (|evt_i);
    assign handshake = (state_q == ST_SEND) & wr_ready_i;

    irq_pend_arb #(.NUM_VEC(NUM_VEC), .VW(VW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (msi_set),
        .clr_en_i  (handshake),
        .clr_idx_i (vec_q),
        .any_o     (pend_any),
        .pick_o    (pick)
    );

    irq_msg_fmt #(.VW(VW), .DATA_W(MSG_DATA_W), .EXP_W(MC_EXP_W)) u_fmt (
        .base_i (cfg_status_i[STAT_DATA_LSB +: MSG_DATA_W]),
        .exp_i  (msi_ctrl_i[MC_EXP_LSB +: MC_EXP_W]),
        .vec_i  (pick),
        .data_o (fmt_data)
    );

    irq_hold_cnt #(.MIN_HOLD(MIN_HOLD)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (hold_start),
        .done_o  (hold_done)
    );

    // legacy pending flag: a new event wins over a software clear
    always_ff @(posedge clk) begin
        if (!rst_n) leg_pend_q <= 1'b0;
        else        leg_pend_q <= (leg_pend_q & ~legacy_clr_i) | leg_set;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_any && issue_ok)      state_d = ST_SEND;
                else if (leg_pend_q && leg_ok) state_d = ST_LEG_HOLD;
            end
            ST_SEND: begin
                if (wr_ready_i) state_d = ST_IDLE;
            end
            ST_LEG_HOLD: begin
                if (hold_done) state_d = leg_pend_q ? ST_LEG_ON : ST_IDLE;
            end
            ST_LEG_ON: begin
                if (!leg_pend_q) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign hold_start = (state_q == ST_IDLE) && (state_d == ST_LEG_HOLD);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture when a write is launched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if ((state_q == ST_IDLE) && (state_d == ST_SEND)) begin
            vec_q  <= pick;
            addr_q <= cfg_status_i[MSG_ADDR_W-1:0];
            data_q <= fmt_data;
        end
    end

    // outputs decoded from state
    always_comb begin
        wr_valid_o   = 1'b0;
        legacy_req_o = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_SEND:     wr_valid_o   = 1'b1;
            ST_LEG_HOLD: legacy_req_o = 1'b1;
            ST_LEG_ON:   legacy_req_o = 1'b1;
            default:     ;
        endcase
        wr_addr_o = addr_q;
        wr_data_o = data_q;
    end
endmodule

// File: rtl/irq_req_ctrl_chk.sv
module irq_req_ctrl_chk #(
    parameter int MIN_HOLD = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic [81:0] cfg_status_i,
    input logic [15:0] msix_ctrl_i,
    input logic        wr_ready_i,
    input logic        wr_valid_o,
    input logic [63:0] wr_addr_o,
    input logic [15:0] wr_data_o,
    input logic        legacy_req_o
);
    logic [31:0] hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n)            hi_run <= '0;
        else if (!legacy_req_o) hi_run <= '0;
        else if (hi_run != 32'hFFFF_FFFF) hi_run <= hi_run + 32'd1;
    end

    AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> wr_valid_o); // R5

    AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> ($stable(wr_addr_o) && $stable(wr_data_o))); // R5

    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid_o) |-> $past(cfg_status_i[81] && cfg_status_i[80]
                                    && !(msix_ctrl_i[15] && msix_ctrl_i[14]))); // R2

    AST_LEGACY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(legacy_req_o) |-> $past(!cfg_status_i[80] && !msix_ctrl_i[15])); // R7

    AST_LEGACY_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(legacy_req_o) |-> (hi_run >= 32'(MIN_HOLD))); // R9
endmodule

bind irq_req_ctrl irq_req_ctrl_chk #(.MIN_HOLD(MIN_HOLD)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_status_i (cfg_status_i),
    .msix_ctrl_i  (msix_ctrl_i),
    .wr_ready_i   (wr_ready_i),
    .wr_valid_o   (wr_valid_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .legacy_req_o (legacy_req_o)
);

// File: tb/test_irq_req_ctrl.sv
module test_irq_req_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 8;
    localparam int HOLD       = 5;
    localparam int WD_CYCLES  = 150000;
    localparam logic [63:0] ADDR = 64'hFEE0_1234_5678_9AB0;
    localparam logic [15:0] BASE = 16'h4A5F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NV-1:0] evt = '0;
    logic [81:0]   status = '0;
    logic [15:0]   mctl = '0;
    logic [15:0]   xctl = '0;
    logic          lclr = 1'b0;
    logic          ready = 1'b0;
    logic          wr_valid_o;
    logic [63:0]   wr_addr_o;
    logic [15:0]   wr_data_o;
    logic          legacy_req_o;

    int checks = 0;
    int fails  = 0;
    logic [NV-1:0] model_pend = '0;
    int log_n = 0;
    logic [15:0] log_d [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_req_ctrl #(.NUM_VEC(NV), .MIN_HOLD(HOLD)) i_irq_req_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt),
        .cfg_status_i (status),
        .msi_ctrl_i   (mctl),
        .msix_ctrl_i  (xctl),
        .legacy_clr_i (lclr),
        .wr_ready_i   (ready),
        .wr_valid_o   (wr_valid_o),
        .wr_addr_o    (wr_addr_o),
        .wr_data_o    (wr_data_o),
        .legacy_req_o (legacy_req_o)
    );

    function automatic logic [15:0] exp_data(logic [15:0] b, int n, int v);
        logic [15:0] m;
        m = (16'd1 << n) - 16'd1;
        return (b & ~m) | (16'(v) & m);
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic set_msi(bit me, bit en, int n);
        status = {me, en, BASE, ADDR};
        mctl   = 16'(n) << 4;
    endtask

    // one clock: record a handshake due at the coming edge, then advance
    task automatic tick();
        #1;
        if (wr_valid_o && ready) begin
            if (log_n < 16) log_d[log_n] = wr_data_o;
            log_n++;
            model_pend[wr_data_o[2:0]] = 1'b0;
        end
        if (status[81] && status[80]) model_pend = model_pend | evt;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(int k);
        for (int i = 0; i < k; i++) tick();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int hi;
        logic [15:0] d0;
        void'($urandom(32'd20240611));
        @(negedge clk);
        ticks(3);
        check(wr_valid_o == 1'b0 && legacy_req_o == 1'b0, "R1 reset outputs",
              {wr_valid_o, legacy_req_o}, 0);
        rst_n = 1'b1;
        tick();

        // R2/R3: single vector, n=3
        set_msi(1, 1, 3);
        evt = 8'h08; tick(); evt = '0; tick();
        check(wr_valid_o == 1'b1, "R2 valid after event", wr_valid_o, 1);
        check(wr_addr_o == ADDR, "R2 address", wr_addr_o, ADDR);
        check(wr_data_o == exp_data(BASE, 3, 3), "R3 payload vector 3",
              wr_data_o, exp_data(BASE, 3, 3));
        // R5: held while not ready
        d0 = wr_data_o;
        ticks(3);
        check(wr_valid_o == 1'b1 && wr_data_o == d0, "R5 held without ready",
              {wr_valid_o, wr_data_o}, {1'b1, d0});
        ready = 1'b1; tick(); ready = 1'b0; tick();
        check(wr_valid_o == 1'b0, "R4 cleared after handshake", wr_valid_o, 0);

        // R4: lowest first
        log_n = 0;
        evt = 8'h64; tick(); evt = '0;
        ready = 1'b1; ticks(12); ready = 1'b0;
        check(log_n == 3, "R4 three writes", log_n, 3);
        check(log_d[0][2:0] == 3'd2 && log_d[1][2:0] == 3'd5 && log_d[2][2:0] == 3'd6,
              "R4 order 2,5,6", {log_d[0][2:0], log_d[1][2:0], log_d[2][2:0]}, {3'd2, 3'd5, 3'd6});

        // R3: truncation with n=1 and pass-through with n=0
        set_msi(1, 1, 1);
        evt = 8'h40; tick(); evt = '0; tick();
        check(wr_data_o == exp_data(BASE, 1, 6), "R3 truncated to 1 bit",
              wr_data_o, exp_data(BASE, 1, 6));
        ready = 1'b1; tick(); ready = 1'b0; tick();
        set_msi(1, 1, 0);
        evt = 8'h40; tick(); evt = '0; tick();
        check(wr_data_o == BASE, "R3 n=0 base data", wr_data_o, BASE);
        ready = 1'b1; tick(); ready = 1'b0; tick();

        // R6: MSI-X function mask holds off, pending kept
        set_msi(1, 1, 3);
        xctl = 16'hC000;
        evt = 8'h02; tick(); evt = '0; ticks(6);
        check(wr_valid_o == 1'b0, "R6 no write while masked", wr_valid_o, 0);
        xctl = 16'h0000; tick();
        check(wr_valid_o == 1'b1 && wr_data_o == exp_data(BASE, 3, 1),
              "R6 pending served after unmask", wr_data_o, exp_data(BASE, 3, 1));
        ready = 1'b1; tick(); ready = 1'b0; tick();

        // R7: master off, MSI on -> neither path; then MSI off -> legacy rises
        set_msi(0, 1, 3);
        evt = 8'h01; tick(); evt = '0; ticks(5);
        check(wr_valid_o == 1'b0 && legacy_req_o == 1'b0, "R7 no request while MSI enabled",
              {wr_valid_o, legacy_req_o}, 0);
        set_msi(0, 0, 3); ticks(2);
        check(legacy_req_o == 1'b1, "R7 legacy rises when allowed", legacy_req_o, 1);
        // R8: stays high until clear
        ticks(20);
        check(legacy_req_o == 1'b1, "R8 held until clear", legacy_req_o, 1);
        lclr = 1'b1; tick(); lclr = 1'b0; ticks(2);
        check(legacy_req_o == 1'b0, "R8 drops after clear", legacy_req_o, 0);
        ticks(3);

        // R9: early clear still gives minimum width
        evt = 8'h10; tick(); evt = '0; lclr = 1'b1; tick(); lclr = 1'b0;
        hi = 0;
        for (int i = 0; i < 14; i++) begin
            if (legacy_req_o) hi++;
            tick();
        end
        check(hi == HOLD, "R9 minimum width", hi, HOLD);

        // R8: event in the same cycle as clear wins
        evt = 8'h01; tick(); evt = '0; ticks(8);
        evt = 8'h02; lclr = 1'b1; tick(); evt = '0; lclr = 1'b0; ticks(4);
        check(legacy_req_o == 1'b1, "R8 event beats clear", legacy_req_o, 1);
        lclr = 1'b1; tick(); lclr = 1'b0; ticks(3);
        check(legacy_req_o == 1'b0, "R8 final clear", legacy_req_o, 0);

        // random phase: R2, R3, R4
        set_msi(1, 1, 3);
        model_pend = '0;
        for (int i = 0; i < 600; i++) begin
            logic [NV-1:0] pend_before;
            evt = ($urandom % 4 == 0) ? NV'(1) << ($urandom % NV) : '0;
            ready = 1'($urandom % 2);
            pend_before = model_pend;
            #1;
            if (wr_valid_o && ready) begin
                check(pend_before[wr_data_o[2:0]] == 1'b1, "R4 served vector was pending",
                      pend_before, wr_data_o[2:0]);
                check(wr_data_o[15:3] == BASE[15:3] && wr_addr_o == ADDR,
                      "R2 R3 random payload", {wr_data_o, wr_addr_o}, {BASE, ADDR});
            end
            tick();
        end
        evt = '0; ready = 1'b1; ticks(40); ready = 1'b0;
        check(model_pend == '0 && wr_valid_o == 1'b0, "R4 all events served",
              model_pend, 0);

        finish_run();
    end
endmodule